// File: doc/BRIEF.md
# Hot-Plug Bring-Up Sequencer

This block steps one video bridge port from power-off to protected video in a fixed order. The supply must be stable first, then the bridge reset is released, then the plug indication is debounced, then a single capability read is requested, then output timing is enabled, and last the content-protection engine is allowed to run. A debounced unplug or a drop of the 5V-present line sends the port back to the off state with reset asserted, and that return is counted as a plug event.

The raw 5V-present and hot-plug levels are asynchronous. Each passes through a two-flop synchronizer before any decision uses it. Short hot-plug glitches never restart the whole chain. They only restart the stability window that guards the capability read. The capability cache is cleared and a read is requested exactly once per detect event. Two saturating counters track observed DDC read strobes and plug events, and a synchronous clear input zeroes both.

The block carries no pixel or packet stream, so it has no valid/ready interface and nothing at its edge can apply back-pressure. Every pin is either a plain level or a one-cycle strobe. The strobe inputs (`ddc_act`, `edid_done`) are synchronous to `clk`.

Top module: `hotplug_seq`

## Requirements
- R1: Each raw input passes through a two-flop synchronizer. `rst_release` rises only after the synchronized 5V-present level has been high for PWR_STABLE consecutive cycles. Any low sample restarts that count. With the raw input raised just before edge 1, `rst_release` is first high after edge PWR_STABLE+2.
- R2: `hpd_out` rises only after `rst_release` is high. The synchronized hot-plug level must then be high for HPD_DEB consecutive cycles, counted from the reset release, so a level already high at release is high on edge HPD_DEB after release.
- R3: `edid_req` fires only after the synchronized hot-plug level has been high for `stab_window`+1 consecutive cycles after `hpd_out` rose. Any low sample restarts the window. A low run shorter than HPD_DEB cycles leaves `hpd_out` high.
- R4: `edid_req` is a single-cycle pulse, issued exactly once per detect event. A bounce during the stability window or during the read does not issue a second request.
- R5: `cache_clr` is a single-cycle pulse in the same cycle that `hpd_out` rises. It is issued once per detect event and never on a glitch that does not drop `hpd_out`.
- R6: `timing_en` is high in the cycle after `edid_done` is sampled while the read is outstanding. If `timing_ack` has not been seen by edge `timing_limit`+1 after `timing_en` rose, `timeout_flag` rises. The flag stays high until the next detect event.
- R7: `prot_en` is high only while `timing_ack` has been received for the current event, `timing_en` is high and `cfg_prot_en` is 1. With `cfg_prot_en` = 0 it stays low.
- R8: A synchronized 5V low, or a synchronized hot-plug low held for HPD_DEB consecutive cycles while `hpd_out` is high, returns the block to the off state. In the off state `rst_release`, `hpd_out`, `timing_en` and `prot_en` are 0, and `plug_cnt` increments by one. A 5V drop just before edge 1 clears `rst_release` on edge 3.
- R9: `read_cnt` adds one for every cycle `ddc_act` is high. `plug_cnt` and `read_cnt` both saturate at 2^CNT_W-1. `clr_cnt` zeroes both on the next edge.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_cnt | input | 1 | Synchronous clear of both counters |
| pwr_raw | input | 1 | Raw 5V-present level, asynchronous |
| hpd_raw | input | 1 | Raw hot-plug level, asynchronous |
| ddc_act | input | 1 | DDC read-activity strobe |
| edid_done | input | 1 | Capability read finished strobe |
| timing_ack | input | 1 | Output timing generator running |
| cfg_prot_en | input | 1 | Allow content-protection start |
| stab_window | input | WIN_W | Stability window length minus one, in cycles |
| timing_limit | input | WIN_W | Cycles allowed for timing acknowledge |
| rst_release | output | 1 | Bridge reset released (1 = out of reset) |
| hpd_out | output | 1 | Debounced plug indication |
| edid_req | output | 1 | One-shot capability read request |
| cache_clr | output | 1 | One-shot capability cache clear |
| timing_en | output | 1 | Output timing enable |
| prot_en | output | 1 | Content-protection enable |
| timeout_flag | output | 1 | Timing acknowledge missed the limit |
| read_cnt | output | CNT_W | Saturating DDC read count |
| plug_cnt | output | CNT_W | Saturating plug-event count |

## Verification
The reset release is due on edge PWR_STABLE+2 after a 5V rise. The plug indication and cache clear are due on edge HPD_DEB after the release. The read request is due on edge `stab_window`+1 after that, the timing enable one edge after `edid_done`, and the timeout on edge `timing_limit`+1 after the timing enable. A power drop clears the reset release on edge 3 and a debounced unplug returns to off on edge HPD_DEB+3. Inputs are driven on falling edges and the bench steps an exact number of rising edges. For each of these results it checks one edge early that the output is still low and on the due edge that it is high. Pulses are counted at rising edges, so each count is read at least one cycle after the pulse, and glitch cases confirm that the counts did not move.

// File: rtl/hps_pkg.sv
package hps_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_HPD,
    ST_STABLE,
    ST_EDID,
    ST_TIMING,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/hps_sync2.sv
module hps_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hps_run_det.sv
// Flags once the input has held LEVEL for N consecutive cycles.
module hps_run_det #(
  parameter int   N     = 8,
  parameter logic LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);
  localparam int RW = $clog2(N + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)              run <= '0;
    else if (din != LEVEL)   run <= '0;
    else if (run != RW'(N))  run <= run + 1'b1;
  end

  assign hit = (run == RW'(N));
endmodule

// File: rtl/hps_sat_cnt.sv
module hps_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)      cnt <= '0;
    else if (inc && !(&cnt)) cnt <= cnt + 1'b1;
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt) && inc && !clr) |=> (&cnt));
endmodule

// File: rtl/hotplug_seq.sv
module hotplug_seq
  import hps_pkg::*;
#(
  parameter int PWR_STABLE = 16,
  parameter int HPD_DEB    = 8,
  parameter int CNT_W      = 8,
  parameter int WIN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_cnt,
  input  logic             pwr_raw,
  input  logic             hpd_raw,
  input  logic             ddc_act,
  input  logic             edid_done,
  input  logic             timing_ack,
  input  logic             cfg_prot_en,
  input  logic [WIN_W-1:0] stab_window,
  input  logic [WIN_W-1:0] timing_limit,
  output logic             rst_release,
  output logic             hpd_out,
  output logic             edid_req,
  output logic             cache_clr,
  output logic             timing_en,
  output logic             prot_en,
  output logic             timeout_flag,
  output logic [CNT_W-1:0] read_cnt,
  output logic [CNT_W-1:0] plug_cnt
);
  localparam int FIX_W = $clog2(PWR_STABLE + HPD_DEB + 1);
  localparam int CW    = (WIN_W > FIX_W) ? WIN_W : FIX_W;

  seq_state_e    state, nstate;
  logic [CW-1:0] cnt, ncnt;
  logic          pwr_s, hpd_s, hpd_lost, hpd_up;
  logic          plug_inc, fire_req, fire_clr, set_tmo;
  logic          req_sent, done_seen;

  hps_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hpd_raw, pwr_raw}), .q({hpd_s, pwr_s})
  );

  hps_run_det #(.N(HPD_DEB), .LEVEL(1'b0)) u_lost (
    .clk(clk), .rst_n(rst_n), .din(hpd_s), .hit(hpd_lost)
  );

  assign hpd_up = (state == ST_STABLE) || (state == ST_EDID) ||
                  (state == ST_TIMING) || (state == ST_RUN);

  always_comb begin
    nstate   = state;
    ncnt     = cnt;
    plug_inc = 1'b0;
    fire_req = 1'b0;
    fire_clr = 1'b0;
    set_tmo  = 1'b0;
    if (state != ST_OFF && !pwr_s) begin
      nstate = ST_OFF; ncnt = '0; plug_inc = 1'b1;
    end else if (hpd_up && hpd_lost) begin
      nstate = ST_OFF; ncnt = '0; plug_inc = 1'b1;
    end else begin
      case (state)
        ST_OFF: begin
          if (!pwr_s) ncnt = '0;
          else if (cnt == CW'(PWR_STABLE - 1)) begin
            nstate = ST_WAIT_HPD; ncnt = '0;
          end else ncnt = cnt + 1'b1;
        end
        ST_WAIT_HPD: begin
          if (!hpd_s) ncnt = '0;
          else if (cnt == CW'(HPD_DEB - 1)) begin
            nstate = ST_STABLE; ncnt = '0; fire_clr = 1'b1;
          end else ncnt = cnt + 1'b1;
        end
        ST_STABLE: begin
          if (!hpd_s) ncnt = '0;
          else if (cnt == CW'(stab_window)) begin
            nstate = ST_EDID; ncnt = '0; fire_req = !req_sent;
          end else ncnt = cnt + 1'b1;
        end
        ST_EDID: begin
          if (!hpd_s) begin
            nstate = ST_STABLE; ncnt = '0;
          end else if (done_seen || edid_done) begin
            nstate = ST_TIMING; ncnt = '0;
          end
        end
        ST_TIMING: begin
          if (timing_ack) nstate = ST_RUN;
          else if (cnt == CW'(timing_limit)) set_tmo = 1'b1;
          else ncnt = cnt + 1'b1;
        end
        ST_RUN: ;
        default: begin nstate = ST_OFF; ncnt = '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_OFF;
      cnt          <= '0;
      edid_req     <= 1'b0;
      cache_clr    <= 1'b0;
      req_sent     <= 1'b0;
      done_seen    <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      state     <= nstate;
      cnt       <= ncnt;
      edid_req  <= fire_req;
      cache_clr <= fire_clr;
      if (fire_clr)      req_sent <= 1'b0;
      else if (fire_req) req_sent <= 1'b1;
      if (fire_clr) done_seen <= 1'b0;
      else if (edid_done && req_sent && hpd_up) done_seen <= 1'b1;
      if (fire_clr)     timeout_flag <= 1'b0;
      else if (set_tmo) timeout_flag <= 1'b1;
    end
  end

  assign rst_release = (state != ST_OFF);
  assign hpd_out     = hpd_up;
  assign timing_en   = (state == ST_TIMING) || (state == ST_RUN);
  assign prot_en     = (state == ST_RUN) && cfg_prot_en;

  hps_sat_cnt #(.W(CNT_W)) u_read_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(ddc_act), .cnt(read_cnt)
  );

  hps_sat_cnt #(.W(CNT_W)) u_plug_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(plug_inc), .cnt(plug_cnt)
  );

  // R7
  prot_after_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en |-> (timing_en && cfg_prot_en));
  // R2
  hpd_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_out |-> rst_release);
  // R4
  edid_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edid_req |=> !edid_req);
  // R5
  cache_clr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_clr |-> (hpd_out && !$past(hpd_out)));
  // R8
  pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_release && !pwr_s) |=> !rst_release);
  // R6
  tmo_needs_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> timing_en);
endmodule

// File: tb/hotplug_seq_tb.sv
module hotplug_seq_tb;
  localparam int PWR_STABLE = 16;
  localparam int HPD_DEB    = 8;
  localparam int CNT_W      = 8;
  localparam int WIN_W      = 16;
  localparam int WIN        = 10;
  localparam int TLIM       = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_cnt = 1'b0, pwr_raw = 1'b0, hpd_raw = 1'b1, ddc_act = 1'b0;
  logic edid_done = 1'b0, timing_ack = 1'b0, cfg_prot_en = 1'b0;
  logic [WIN_W-1:0] stab_window = WIN_W'(WIN);
  logic [WIN_W-1:0] timing_limit = WIN_W'(TLIM);
  logic rst_release, hpd_out, edid_req, cache_clr, timing_en, prot_en, timeout_flag;
  logic [CNT_W-1:0] read_cnt, plug_cnt;

  int n_chk = 0, n_err = 0, n_req = 0, n_clr = 0;

  always #10 clk = ~clk;

  hotplug_seq #(.PWR_STABLE(PWR_STABLE), .HPD_DEB(HPD_DEB), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .pwr_raw(pwr_raw), .hpd_raw(hpd_raw),
    .ddc_act(ddc_act), .edid_done(edid_done), .timing_ack(timing_ack),
    .cfg_prot_en(cfg_prot_en), .stab_window(stab_window), .timing_limit(timing_limit),
    .rst_release(rst_release), .hpd_out(hpd_out), .edid_req(edid_req),
    .cache_clr(cache_clr), .timing_en(timing_en), .prot_en(prot_en),
    .timeout_flag(timeout_flag), .read_cnt(read_cnt), .plug_cnt(plug_cnt)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (edid_req)  n_req++;
      if (cache_clr) n_clr++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R10 rst_release", rst_release, 0);
    chk("R10 hpd_out", hpd_out, 0);
    chk("R10 edid_req", edid_req, 0);
    chk("R10 cache_clr", cache_clr, 0);
    chk("R10 timing_en", timing_en, 0);
    chk("R10 prot_en", prot_en, 0);
    chk("R10 timeout_flag", timeout_flag, 0);
    chk("R10 read_cnt", int'(read_cnt), 0);
    chk("R10 plug_cnt", int'(plug_cnt), 0);
  endtask

  task automatic t_power_glitch;
    pwr_raw = 1'b1; step(5);
    pwr_raw = 1'b0; step(20);
    chk("R1 short 5V pulse keeps reset", rst_release, 0);
  endtask

  task automatic t_power_on;
    pwr_raw = 1'b1;
    step(PWR_STABLE + 1);
    chk("R1 reset held one edge early", rst_release, 0);
    step(1);
    chk("R1 reset released on time", rst_release, 1);
    step(HPD_DEB - 1);
    chk("R2 hpd one edge early", hpd_out, 0);
    step(1);
    chk("R2 hpd asserted on time", hpd_out, 1);
    chk("R5 cache clear with hpd rise", cache_clr, 1);
  endtask

  task automatic t_window;
    step(WIN);
    chk("R3 request one edge early", edid_req, 0);
    step(1);
    chk("R3 request after window", edid_req, 1);
    step(1);
    chk("R4 request is one cycle", edid_req, 0);
    ddc_act = 1'b1; step(1); ddc_act = 1'b0;
    edid_done = 1'b1; step(1); edid_done = 1'b0;
    chk("R6 timing enable after done", timing_en, 1);
    chk("R9 one read strobe counted", int'(read_cnt), 1);
  endtask

  task automatic t_prot;
    cfg_prot_en = 1'b0; timing_ack = 1'b1; step(3); timing_ack = 1'b0;
    chk("R7 protection held off by config", prot_en, 0);
    chk("R7 timing still running", timing_en, 1);
    cfg_prot_en = 1'b1; step(1);
    chk("R7 protection enabled last", prot_en, 1);
  endtask

  task automatic t_glitch_run;
    int r0, c0;
    r0 = n_req; c0 = n_clr;
    hpd_raw = 1'b0; step(3); hpd_raw = 1'b1; step(20);
    chk("R5 glitch keeps hpd", hpd_out, 1);
    chk("R4 glitch issues no read", n_req, r0);
    chk("R5 glitch issues no cache clear", n_clr, c0);
  endtask

  task automatic t_unplug;
    int p0;
    p0 = int'(plug_cnt);
    hpd_raw = 1'b0; step(14);
    chk("R8 unplug asserts reset", rst_release, 0);
    chk("R8 unplug drops hpd", hpd_out, 0);
    chk("R8 unplug drops timing", timing_en, 0);
    chk("R8 unplug drops protection", prot_en, 0);
    chk("R8 plug event counted", int'(plug_cnt), p0 + 1);
  endtask

  task automatic t_replug_bounce;
    int r0, c0;
    bit seen;
    r0 = n_req; c0 = n_clr;
    step(30);
    hpd_raw = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      step(1);
      if (hpd_out) seen = 1'b1;
    end
    chk("R2 replug raises hpd", hpd_out, 1);
    step(4);
    hpd_raw = 1'b0; step(3); hpd_raw = 1'b1;
    chk("R3 bounce keeps hpd", hpd_out, 1);
    step(11);
    chk("R3 bounce restarts window", n_req, r0);
    seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      step(1);
      if (edid_req) seen = 1'b1;
    end
    step(2);
    chk("R4 one read per plug event", n_req, r0 + 1);
    chk("R5 one cache clear per detect", n_clr, c0 + 1);
  endtask

  task automatic t_timeout;
    edid_done = 1'b1; step(1); edid_done = 1'b0;
    chk("R6 timing enable on replug", timing_en, 1);
    step(TLIM);
    chk("R6 no timeout one edge early", timeout_flag, 0);
    step(1);
    chk("R6 timeout raised", timeout_flag, 1);
    chk("R7 no protection before ack", prot_en, 0);
    timing_ack = 1'b1; step(1); timing_ack = 1'b0;
    chk("R7 protection after late ack", prot_en, 1);
  endtask

  task automatic t_power_loss;
    int p0;
    p0 = int'(plug_cnt);
    pwr_raw = 1'b0; step(2);
    chk("R8 reset still released two edges after drop", rst_release, 1);
    step(1);
    chk("R8 5V loss asserts reset", rst_release, 0);
    chk("R8 5V loss counted", int'(plug_cnt), p0 + 1);
  endtask

  task automatic t_counters;
    ddc_act = 1'b1; step(300); ddc_act = 1'b0;
    chk("R9 read count saturates", int'(read_cnt), (1 << CNT_W) - 1);
    clr_cnt = 1'b1; step(1); clr_cnt = 1'b0;
    chk("R9 clear zeroes reads", int'(read_cnt), 0);
    chk("R9 clear zeroes plugs", int'(plug_cnt), 0);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_power_glitch();
    t_power_on();
    t_window();
    t_prot();
    t_glitch_run();
    t_unplug();
    t_replug_bounce();
    t_timeout();
    t_power_loss();
    t_counters();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule